// File: doc/BRIEF.md
# Priority Interrupt Level Arbiter

This block picks which interrupt level, if any, a processor core should take next. It merges sixteen external level-request lines with the level bits of a software interrupt register. It compares the result against the core's current mask level and drives a hard-interrupt request together with a 7-bit trap-type index. The index is the external-interrupt base 0x40 ORed with the winning level number.

The software interrupt register is 17 bits wide. Bits 15..1 request levels 15..1 directly. Bit 0 (tick match) and bit 16 (system tick match) are timer flags, and either of them raises level 14 instead of its own position. The core can set, clear or overwrite the register through single-cycle strobes. The arbiter also takes account of trap state. A pending vectored interrupt freezes the outputs. A new level is held back while the core is already servicing a higher external-interrupt trap at the current trap level.

Arbitration is registered. The outputs reflect the inputs, and the software register value that a strobe produces, one clock after they are presented.

Top module: `irq_level_arb`

## Requirements
- R1: After reset `irq_req_o` is 0, `irq_tt_o` is 0 and `swi_q_o` is 0.
- R2: A write strobe loads `swi_data_i` into the software register. A clear strobe ANDs the register with `~swi_data_i`, and a set strobe ORs the register with `swi_data_i`. When strobes coincide, write wins over clear and clear wins over set. The new value appears on `swi_q_o` one clock later.
- R3: The pending vector is the OR of `ext_lvl_i` with register bits 15..1. Register bit 0 or bit 16 forces pending bit 14, and neither of them feeds its own position.
- R4: When enabled, with no vectored interrupt pending and no suppression, the highest pending bit i above `mask_lvl_i` drives `irq_tt_o` = 0x40 | i and `irq_req_o` = 1 one clock later.
- R5: If the pending vector is numerically below (2 << `mask_lvl_i`), then one clock later `irq_req_o` is 0 and `irq_tt_o` is 0, whatever the state of the enable.
- R6: With `int_en_i` low and no vectored interrupt pending, `irq_req_o` and `irq_tt_o` are 0 one clock later.
- R7: While `vec_pend_i` is 1, both outputs keep their previous values in the next cycle.
- R8: If `trap_lvl_i` is nonzero, `cur_tt_i[8:4]` equals 0x4 and `cur_tt_i` is greater than the new trap type, the outputs keep their previous values.
- R9: With `trap_lvl_i` at 0, or `cur_tt_i` outside 0x40..0x4F, or `cur_tt_i` not greater than the new type, the new level is raised as in R4.
- R10: With `mask_lvl_i` at 15 no level is ever eligible, so the outputs are 0 one clock later (unless held by R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_lvl_i | input | 16 | External level requests, bit i = level i |
| mask_lvl_i | input | 4 | Current interrupt mask level |
| int_en_i | input | 1 | Global interrupt enable |
| vec_pend_i | input | 1 | Vectored interrupt pending; freezes arbitration |
| trap_lvl_i | input | 3 | Current trap level |
| cur_tt_i | input | 9 | Trap type saved at the current trap level |
| swi_set_i | input | 1 | Software register set strobe |
| swi_clr_i | input | 1 | Software register clear strobe |
| swi_wr_i | input | 1 | Software register write strobe |
| swi_data_i | input | 17 | Operand for the software register strobes |
| swi_q_o | output | 17 | Software interrupt register value |
| irq_req_o | output | 1 | Hard-interrupt request to the core |
| irq_tt_o | output | 7 | Trap type of the requested level |

## Verification
The bound checker watches several rules on every cycle. The outputs freeze under a pending vectored interrupt. The request drops when interrupts are disabled or the mask is at 15. A write lands verbatim in the register. An idle request always carries a zero index, and an active one carries an index in 0x41..0x4F. Directed scenarios show the rest: which level wins for a given mask, the threshold edge, the timer bits folding into level 14, strobe precedence, and suppression under nested external-interrupt traps together with the cases that lift it.

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
  parameter int LVL_N    = 16,
  parameter int MASK_W   = 4,
  parameter int TL_W     = 3,
  parameter int TT_W     = 9,
  parameter int IDX_W    = 7,
  parameter int EXT_BASE = 'h40,
  parameter int TICK_LVL = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_N-1:0]  ext_lvl_i,
  input  logic [MASK_W-1:0] mask_lvl_i,
  input  logic              int_en_i,
  input  logic              vec_pend_i,
  input  logic [TL_W-1:0]   trap_lvl_i,
  input  logic [TT_W-1:0]   cur_tt_i,
  input  logic              swi_set_i,
  input  logic              swi_clr_i,
  input  logic              swi_wr_i,
  input  logic [LVL_N:0]    swi_data_i,
  output logic [LVL_N:0]    swi_q_o,
  output logic              irq_req_o,
  output logic [IDX_W-1:0]  irq_tt_o
);
  localparam int SW_W  = LVL_N + 1;
  localparam int LVL_W = $clog2(LVL_N);

  logic [SW_W-1:0]  swi_q, swi_nx;
  logic [LVL_N-1:0] pend;
  logic [SW_W-1:0]  thresh;
  logic             below, tick, blocked;
  logic [LVL_W-1:0] top;
  logic [IDX_W-1:0] new_tt;

  always_comb begin
    swi_nx = swi_q;
    if (swi_wr_i)       swi_nx = swi_data_i;
    else if (swi_clr_i) swi_nx = swi_q & ~swi_data_i;
    else if (swi_set_i) swi_nx = swi_q | swi_data_i;
  end

  assign tick   = swi_nx[0] | swi_nx[LVL_N];
  assign pend   = ext_lvl_i | {swi_nx[LVL_N-1:1], 1'b0}
                | (tick ? (LVL_N'(1) << TICK_LVL) : '0);
  assign thresh = SW_W'(2) << mask_lvl_i;
  assign below  = {1'b0, pend} < thresh;

  always_comb begin
    top = '0;
    for (int i = 0; i < LVL_N; i++)
      if (pend[i]) top = LVL_W'(i);
  end

  assign new_tt  = IDX_W'(EXT_BASE) | IDX_W'(top);
  assign blocked = (trap_lvl_i != '0)
                && (cur_tt_i[TT_W-1:4] == (TT_W-4)'(EXT_BASE >> 4))
                && (cur_tt_i > TT_W'(new_tt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swi_q     <= '0;
      irq_req_o <= 1'b0;
      irq_tt_o  <= '0;
    end else begin
      swi_q <= swi_nx;
      if (vec_pend_i) begin
        irq_req_o <= irq_req_o;
      end else if (below || !int_en_i) begin
        irq_req_o <= 1'b0;
        irq_tt_o  <= '0;
      end else if (!blocked && irq_tt_o != new_tt) begin
        irq_req_o <= 1'b1;
        irq_tt_o  <= new_tt;
      end
    end
  end

  assign swi_q_o = swi_q;
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk #(
  parameter int LVL_N  = 16,
  parameter int MASK_W = 4,
  parameter int IDX_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MASK_W-1:0] mask_lvl_i,
  input logic              int_en_i,
  input logic              vec_pend_i,
  input logic              swi_wr_i,
  input logic [LVL_N:0]    swi_data_i,
  input logic [LVL_N:0]    swi_q_o,
  input logic              irq_req_o,
  input logic [IDX_W-1:0]  irq_tt_o
);
  assert_hold_on_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_pend_i |=> ($stable(irq_req_o) && $stable(irq_tt_o)));

  assert_drop_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en_i && !vec_pend_i) |=> (!irq_req_o && irq_tt_o == '0));

  assert_mask_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_lvl_i == '1 && !vec_pend_i) |=> !irq_req_o);

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    swi_wr_i |=> (swi_q_o == $past(swi_data_i)));

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req_o |-> (irq_tt_o == '0));

  assert_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_tt_o[IDX_W-1:4] == 3'b100 && irq_tt_o[3:0] != 4'h0));
endmodule

bind irq_level_arb irq_level_arb_chk #(.LVL_N(LVL_N), .MASK_W(MASK_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mask_lvl_i(mask_lvl_i), .int_en_i(int_en_i),
  .vec_pend_i(vec_pend_i), .swi_wr_i(swi_wr_i), .swi_data_i(swi_data_i),
  .swi_q_o(swi_q_o), .irq_req_o(irq_req_o), .irq_tt_o(irq_tt_o)
);

// File: tb/irq_level_arb_tb_top.sv
module irq_level_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_lvl_i = '0;
  logic [3:0]  mask_lvl_i = '0;
  logic        int_en_i = 1'b0;
  logic        vec_pend_i = 1'b0;
  logic [2:0]  trap_lvl_i = '0;
  logic [8:0]  cur_tt_i = '0;
  logic        swi_set_i = 1'b0, swi_clr_i = 1'b0, swi_wr_i = 1'b0;
  logic [16:0] swi_data_i = '0;
  logic [16:0] swi_q_o;
  logic        irq_req_o;
  logic [6:0]  irq_tt_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_level_arb dut_i (
    .clk(clk), .rst_n(rst_n), .ext_lvl_i(ext_lvl_i), .mask_lvl_i(mask_lvl_i),
    .int_en_i(int_en_i), .vec_pend_i(vec_pend_i), .trap_lvl_i(trap_lvl_i),
    .cur_tt_i(cur_tt_i), .swi_set_i(swi_set_i), .swi_clr_i(swi_clr_i),
    .swi_wr_i(swi_wr_i), .swi_data_i(swi_data_i), .swi_q_o(swi_q_o),
    .irq_req_o(irq_req_o), .irq_tt_o(irq_tt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic req, input logic [6:0] tt);
    chk({tag, " req"}, 32'(irq_req_o), 32'(req));
    chk({tag, " tt"},  32'(irq_tt_o),  32'(tt));
  endtask

  task automatic step();
    @(negedge clk);
    swi_set_i = 1'b0; swi_clr_i = 1'b0; swi_wr_i = 1'b0;
  endtask

  task automatic swi_op(input logic s, input logic c, input logic w, input logic [16:0] d);
    swi_set_i = s; swi_clr_i = c; swi_wr_i = w; swi_data_i = d;
    step();
  endtask

  task automatic quiesce();
    ext_lvl_i = '0; vec_pend_i = 1'b0; trap_lvl_i = '0; cur_tt_i = '0;
    mask_lvl_i = '0; int_en_i = 1'b1;
    swi_op(1'b0, 1'b0, 1'b1, 17'h0);
    step();
  endtask

  task automatic t_reset();
    chk("R1 req", 32'(irq_req_o), 32'd0);
    chk("R1 tt", 32'(irq_tt_o), 32'd0);
    chk("R1 swi", 32'(swi_q_o), 32'd0);
  endtask

  task automatic t_swi_ops();
    mask_lvl_i = 4'hF;
    swi_op(1'b0, 1'b0, 1'b1, 17'h000A5); chk("R2 write", 32'(swi_q_o), 32'h000A5);
    swi_op(1'b1, 1'b0, 1'b0, 17'h10300); chk("R2 set",   32'(swi_q_o), 32'h103A5);
    swi_op(1'b0, 1'b1, 1'b0, 17'h10005); chk("R2 clear", 32'(swi_q_o), 32'h003A0);
    swi_op(1'b1, 1'b1, 1'b1, 17'h00010); chk("R2 wr wins", 32'(swi_q_o), 32'h00010);
    swi_op(1'b1, 1'b1, 1'b0, 17'h00010); chk("R2 clr over set", 32'(swi_q_o), 32'h00000);
  endtask

  task automatic t_basic();
    quiesce();
    ext_lvl_i = 16'h0024; step(); chk_out("R4 bits5,2", 1'b1, 7'h45);
    ext_lvl_i = 16'h8001; step(); chk_out("R4 bit15", 1'b1, 7'h4F);
    mask_lvl_i = 4'd4; ext_lvl_i = 16'h0030; step(); chk_out("R4 mask4", 1'b1, 7'h45);
  endtask

  task automatic t_thresh();
    mask_lvl_i = 4'd5; ext_lvl_i = 16'h0030; step(); chk_out("R5 below", 1'b0, 7'h00);
    int_en_i = 1'b0; ext_lvl_i = 16'h0001; mask_lvl_i = 4'd0; step();
    chk_out("R5 level0 only", 1'b0, 7'h00);
    int_en_i = 1'b1; mask_lvl_i = 4'd5; ext_lvl_i = 16'h0040; step();
    chk_out("R5 just above", 1'b1, 7'h46);
  endtask

  task automatic t_tick();
    quiesce();
    swi_op(1'b0, 1'b0, 1'b1, 17'h00001); chk_out("R3 tick bit0", 1'b1, 7'h4E);
    swi_op(1'b0, 1'b0, 1'b1, 17'h00000); chk_out("R3 cleared", 1'b0, 7'h00);
    swi_op(1'b0, 1'b0, 1'b1, 17'h10000); chk_out("R3 stick bit16", 1'b1, 7'h4E);
    swi_op(1'b0, 1'b0, 1'b1, 17'h00008); chk_out("R3 swi level3", 1'b1, 7'h43);
    ext_lvl_i = 16'h0020; step(); chk_out("R3 ext or swi", 1'b1, 7'h45);
  endtask

  task automatic t_disable();
    quiesce();
    ext_lvl_i = 16'h8000; int_en_i = 1'b0; step(); chk_out("R6 disabled", 1'b0, 7'h00);
    int_en_i = 1'b1; step(); chk_out("R6 reenabled", 1'b1, 7'h4F);
  endtask

  task automatic t_vec();
    vec_pend_i = 1'b1; ext_lvl_i = 16'h0000; int_en_i = 1'b0; step();
    chk_out("R7 hold", 1'b1, 7'h4F);
    int_en_i = 1'b1; ext_lvl_i = 16'h0100; step(); chk_out("R7 hold new", 1'b1, 7'h4F);
    vec_pend_i = 1'b0; step(); chk_out("R7 released", 1'b1, 7'h48);
  endtask

  task automatic t_nest();
    quiesce();
    trap_lvl_i = 3'd1; cur_tt_i = 9'h04A; ext_lvl_i = 16'h0010; step();
    chk_out("R8 suppressed", 1'b0, 7'h00);
    ext_lvl_i = 16'h0800; step(); chk_out("R9 higher raises", 1'b1, 7'h4B);
    ext_lvl_i = 16'h0010; step(); chk_out("R8 hold old", 1'b1, 7'h4B);
    ext_lvl_i = 16'h0000; step();
    trap_lvl_i = 3'd0; ext_lvl_i = 16'h0010; step(); chk_out("R9 level0", 1'b1, 7'h44);
    ext_lvl_i = 16'h0000; step();
    trap_lvl_i = 3'd2; cur_tt_i = 9'h060; ext_lvl_i = 16'h0010; step();
    chk_out("R9 out of group", 1'b1, 7'h44);
    ext_lvl_i = 16'h0000; step();
    cur_tt_i = 9'h044; ext_lvl_i = 16'h0010; step(); chk_out("R9 equal type", 1'b1, 7'h44);
  endtask

  task automatic t_mask15();
    quiesce();
    ext_lvl_i = 16'h8000; step(); chk_out("R10 pre", 1'b1, 7'h4F);
    mask_lvl_i = 4'hF; ext_lvl_i = 16'hFFFF; step(); chk_out("R10 mask15", 1'b0, 7'h00);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_swi_ops();
    t_basic();
    t_thresh();
    t_tick();
    t_disable();
    t_vec();
    t_nest();
    t_mask15();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule